// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block serves one DMA channel for an external peripheral. The peripheral signals that it wants service on an active-low request line. The block passes that line through a synchronizer. Once it accepts the request, it answers with a single-cycle active-low acknowledge, which tells the peripheral it may release the line. After a fixed minimum delay the block asks the system arbiter for the bus. When the bus is granted, it runs two single-beat bus cycles: a read from the source address, whose data is kept in an internal register, and then a write of that data to the destination address.

The channel works in cycle-steal fashion. Each accepted request moves exactly one unit of `XFER_BYTES` bytes. The block then gives up the bus, so the processor can run its own cycles between DMA units.

A configuration strobe loads the source address, the destination address, the byte count and a per-address increment option, and it clears the completion flag. After each unit the addresses advance as configured and the count shrinks. A count of zero raises `done` and blocks further service until the channel is loaded again.

Top module: `dma_req_ctrl`

## Requirements
- R1: `dreq_n` goes through a two-stage synchronizer. If `dreq_n` is low at a rising edge and the channel can accept, `dack_n` first reads low in the cycle that begins on the third rising edge counted from that first edge.
- R2: Each accepted request drives `dack_n` low (0 = acknowledge) for exactly one clock cycle.
- R3: The read bus cycle (`m_valid`=1, `m_we`=0) never starts earlier than `MIN_LAT` (default 4) clocks after the request is sampled. When the grant is already present, it starts exactly `MIN_LAT` cycles after the acknowledge cycle begins.
- R4: While `chan_en`=0, a request produces no acknowledge, no bus request and no transfer.
- R5: A unit is a read at the source address (`m_we`=0). The write at the destination address (`m_we`=1) starts in the cycle right after the read's `m_ta`, and its `m_wdata` equals the captured `m_rdata`.
- R6: `bus_req` rises before any bus cycle. A bus cycle begins only while `bus_gnt`=1. `m_addr`, `m_we` and `m_wdata` stay stable while `m_valid`=1 and `m_ta`=0.
- R7: One request yields one transfer. This holds whether the request is held for four clocks or far longer. The bus is released in the cycle after the write's `m_ta`, and another unit needs the request to be seen negated first.
- R8: After each completed write, the source address grows by `XFER_BYTES` when its increment option is 1, and so does the destination address when its option is 1. Otherwise an address is unchanged.
- R9: Each write lowers the count by `XFER_BYTES`. At zero, `done` goes to 1 and later requests get no acknowledge. `cfg_load` clears `done` and re-arms the channel.
- R10: After reset, `dack_n`=1 and `bus_req`, `m_valid` and `done` are 0. Requests are ignored until a nonzero count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dreq_n | input | 1 | Peripheral request, active low, asynchronous |
| dack_n | output | 1 | Acknowledge pulse to peripheral, active low |
| chan_en | input | 1 | Channel enable |
| cfg_load | input | 1 | Load strobe for configuration; re-arms the channel |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Total bytes to move |
| cfg_src_inc | input | 1 | Advance source after each unit |
| cfg_dst_inc | input | 1 | Advance destination after each unit |
| done | output | 1 | Count exhausted |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| m_valid | output | 1 | Bus cycle active |
| m_we | output | 1 | 1 = write cycle, 0 = read cycle |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | 8*XFER_BYTES | Write data |
| m_rdata | input | 8*XFER_BYTES | Read data |
| m_ta | input | 1 | Transfer acknowledge, ends the current bus cycle |

## Verification
The hardest case to reach from the ports is a request held well past the end of its own transfer. In that case only the re-arm condition, which waits for negation, keeps a second unit from starting. The stimulus holds the request low for forty clocks and counts writes, and it also repeats the test with a request lasting exactly four clocks. A second hard case is the minimum latency while the arbiter withholds the grant. The bench parks the sequencer with the grant forced low, checks that `bus_req` is up and no bus cycle has begun, then releases the grant and confirms that the unit completes. The count is driven to zero so that the blocked-request path and the reload path are both exercised.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_ACK  = 3'd1,
      SQ_HOLD = 3'd2,
      SQ_BREQ = 3'd3,
      SQ_RD   = 3'd4,
      SQ_WR   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic req_on
);

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("dma_req_sync: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] chain_q;

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= din_n;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], din_n};
      end
   end

   assign req_on = ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/dma_req_regs.sv
module dma_req_regs #(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 16,
   parameter int XFER_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_src,
   input  logic [ADDR_W-1:0] ld_dst,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              ld_src_inc,
   input  logic              ld_dst_inc,
   input  logic              step,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              done,
   output logic              live
);

   if (XFER_BYTES < 1 || XFER_BYTES >= (1 << CNT_W)) begin : g_bad_step
      $error("dma_req_regs: XFER_BYTES out of range for CNT_W");
   end

   localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(XFER_BYTES);
   localparam logic [CNT_W-1:0]  C_STEP = CNT_W'(XFER_BYTES);

   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q, cnt_nx;
   logic              sinc_q, dinc_q, done_q;

   if (XFER_BYTES == 1) begin : g_unit_step
      always_comb cnt_nx = cnt_q - 1'b1;
   end else begin : g_sat_step
      always_comb cnt_nx = (cnt_q > C_STEP) ? (cnt_q - C_STEP) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         sinc_q <= 1'b0;
         dinc_q <= 1'b0;
         done_q <= 1'b0;
      end else if (ld) begin
         src_q  <= ld_src;
         dst_q  <= ld_dst;
         cnt_q  <= ld_cnt;
         sinc_q <= ld_src_inc;
         dinc_q <= ld_dst_inc;
         done_q <= 1'b0;
      end else if (step) begin
         src_q  <= src_q + (sinc_q ? A_STEP : '0);
         dst_q  <= dst_q + (dinc_q ? A_STEP : '0);
         cnt_q  <= cnt_nx;
         done_q <= (cnt_nx == '0);
      end
   end

   assign src_addr = src_q;
   assign dst_addr = dst_q;
   assign done     = done_q;
   assign live     = !done_q && (cnt_q != '0);

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
   import dma_req_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 32,
   parameter int MIN_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_on,
   input  logic              chan_en,
   input  logic              live,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic              m_ta,
   output logic              dack_n,
   output logic              bus_req,
   output logic              m_valid,
   output logic              m_we,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   output logic              step
);

   if (MIN_LAT < 3) begin : g_bad_lat
      $error("dma_req_seq: MIN_LAT must be at least 3");
   end

   localparam int HOLD_N = MIN_LAT - 2;
   localparam int HW     = $clog2(HOLD_N + 1);

   seq_state_e        st_q, st_nx;
   logic [HW-1:0]     hcnt_q;
   logic              need_neg_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign accept = (st_q == SQ_IDLE) && req_on && chan_en && live && !need_neg_q;

   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         SQ_IDLE: if (accept) st_nx = SQ_ACK;
         SQ_ACK:  st_nx = SQ_HOLD;
         SQ_HOLD: if (hcnt_q == HW'(1)) st_nx = SQ_BREQ;
         SQ_BREQ: if (bus_gnt) st_nx = SQ_RD;
         SQ_RD:   if (m_ta) st_nx = SQ_WR;
         SQ_WR:   if (m_ta) st_nx = SQ_IDLE;
         default: st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         hcnt_q     <= '0;
         need_neg_q <= 1'b0;
         data_q     <= '0;
      end else begin
         st_q <= st_nx;
         if (st_q == SQ_ACK)       hcnt_q <= HW'(HOLD_N);
         else if (st_q == SQ_HOLD) hcnt_q <= hcnt_q - 1'b1;
         if (accept)               need_neg_q <= 1'b1;
         else if (!req_on)         need_neg_q <= 1'b0;
         if (st_q == SQ_RD && m_ta) data_q <= m_rdata;
      end
   end

   assign dack_n  = (st_q != SQ_ACK);
   assign bus_req = (st_q == SQ_BREQ) || (st_q == SQ_RD) || (st_q == SQ_WR);
   assign m_valid = (st_q == SQ_RD) || (st_q == SQ_WR);
   assign m_we    = (st_q == SQ_WR);
   assign m_addr  = (st_q == SQ_WR) ? dst_addr : src_addr;
   assign m_wdata = data_q;
   assign step    = (st_q == SQ_WR) && m_ta;

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
   parameter int ADDR_W      = 24,
   parameter int CNT_W       = 16,
   parameter int XFER_BYTES  = 4,
   parameter int MIN_LAT     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W     = 8 * XFER_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dreq_n,
   output logic              dack_n,
   input  logic              chan_en,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_src_inc,
   input  logic              cfg_dst_inc,
   output logic              done,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              m_valid,
   output logic              m_we,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic              m_ta
);

   logic              req_on, live, step;
   logic [ADDR_W-1:0] src_addr, dst_addr;

   dma_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_n  (dreq_n),
      .req_on (req_on)
   );

   dma_req_regs #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .XFER_BYTES (XFER_BYTES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld         (cfg_load),
      .ld_src     (cfg_src),
      .ld_dst     (cfg_dst),
      .ld_cnt     (cfg_count),
      .ld_src_inc (cfg_src_inc),
      .ld_dst_inc (cfg_dst_inc),
      .step       (step),
      .src_addr   (src_addr),
      .dst_addr   (dst_addr),
      .done       (done),
      .live       (live)
   );

   dma_req_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .MIN_LAT (MIN_LAT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_on   (req_on),
      .chan_en  (chan_en),
      .live     (live),
      .src_addr (src_addr),
      .dst_addr (dst_addr),
      .bus_gnt  (bus_gnt),
      .m_rdata  (m_rdata),
      .m_ta     (m_ta),
      .dack_n   (dack_n),
      .bus_req  (bus_req),
      .m_valid  (m_valid),
      .m_we     (m_we),
      .m_addr   (m_addr),
      .m_wdata  (m_wdata),
      .step     (step)
   );

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 32,
   parameter int MIN_LAT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dack_n,
   input logic              chan_en,
   input logic              done,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              m_valid,
   input logic              m_we,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_wdata,
   input logic              m_ta
);

   localparam int SW = $clog2(MIN_LAT + 2) + 1;

   logic [SW-1:0] since_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_ack <= '1;
      else if (!dack_n)         since_ack <= SW'(1);
      else if (since_ack != '1) since_ack <= since_ack + 1'b1;
   end

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |=> dack_n);                                            // R2
   AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |-> $past(chan_en));                                    // R4
   AST_NO_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |-> !$past(done));                                      // R9
   AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_valid) |-> (since_ack >= SW'(MIN_LAT)));                // R3
   AST_START_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_valid) |-> (bus_gnt && bus_req && $past(bus_req)));     // R6
   AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ta) |=> (m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_wdata))); // R6
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_we && !$past(m_valid && m_we)) |-> $past(m_valid && !m_we && m_ta)); // R5
   AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_we && m_ta) |=> (!bus_req && !m_valid));          // R7

endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .MIN_LAT (MIN_LAT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dack_n  (dack_n),
   .chan_en (chan_en),
   .done    (done),
   .bus_req (bus_req),
   .bus_gnt (bus_gnt),
   .m_valid (m_valid),
   .m_we    (m_we),
   .m_addr  (m_addr),
   .m_wdata (m_wdata),
   .m_ta    (m_ta)
);

// File: tb/dma_req_ctrl_tb.sv
module dma_req_ctrl_tb;

   localparam int ADDR_W = 24;
   localparam int CNT_W  = 16;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dreq_n = 1'b1;
   logic              dack_n;
   logic              chan_en = 1'b0;
   logic              cfg_load = 1'b0;
   logic [ADDR_W-1:0] cfg_src = '0;
   logic [ADDR_W-1:0] cfg_dst = '0;
   logic [CNT_W-1:0]  cfg_count = '0;
   logic              cfg_src_inc = 1'b0;
   logic              cfg_dst_inc = 1'b0;
   logic              done;
   logic              bus_req;
   logic              bus_gnt;
   logic              gnt_en = 1'b1;
   logic              m_valid, m_we;
   logic [ADDR_W-1:0] m_addr;
   logic [DATA_W-1:0] m_wdata, m_rdata;
   logic              ta_q;

   int checks = 0;
   int errors = 0;
   int dack_cnt = 0;
   int wr_cnt = 0;
   int breq_cyc = 0;
   logic [ADDR_W-1:0] last_rd_addr = '0;
   logic [ADDR_W-1:0] last_wr_addr = '0;
   logic [DATA_W-1:0] last_wr_data = '0;

   always #2.5 clk = ~clk;

   dma_req_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .dreq_n (dreq_n), .dack_n (dack_n),
      .chan_en (chan_en), .cfg_load (cfg_load), .cfg_src (cfg_src),
      .cfg_dst (cfg_dst), .cfg_count (cfg_count), .cfg_src_inc (cfg_src_inc),
      .cfg_dst_inc (cfg_dst_inc), .done (done), .bus_req (bus_req),
      .bus_gnt (bus_gnt), .m_valid (m_valid), .m_we (m_we), .m_addr (m_addr),
      .m_wdata (m_wdata), .m_rdata (m_rdata), .m_ta (ta_q)
   );

   assign bus_gnt = bus_req && gnt_en;
   assign m_rdata = {8'h5A, m_addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ta_q <= 1'b0;
      else        ta_q <= m_valid && !ta_q;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!dack_n) dack_cnt++;
         if (bus_req) breq_cyc++;
         if (m_valid && !m_we && ta_q) last_rd_addr = m_addr;
         if (m_valid && m_we && ta_q) begin
            last_wr_addr = m_addr;
            last_wr_data = m_wdata;
            wr_cnt++;
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] d,
                       logic [CNT_W-1:0] c, logic si, logic di);
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_count = c;
      cfg_src_inc = si; cfg_dst_inc = di; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic pulse_req(int hold);
      @(negedge clk);
      dreq_n = 1'b0;
      tick(hold);
      dreq_n = 1'b1;
   endtask

   task automatic t_reset();
      check("R10 dack_n", 32'(dack_n), 32'd1);
      check("R10 bus_req", 32'(bus_req), 32'd0);
      check("R10 m_valid", 32'(m_valid), 32'd0);
      check("R10 done", 32'(done), 32'd0);
      chan_en = 1'b1;
      pulse_req(4);
      tick(20);
      check("R10 no ack before load", 32'(dack_cnt), 32'd0);
   endtask

   task automatic t_basic();
      int n = 0;
      int m = 0;
      logic [ADDR_W-1:0] a0;
      load(24'h001000, 24'h002000, 16'd16, 1'b1, 1'b0);
      @(negedge clk);
      dreq_n = 1'b0;
      do begin
         @(negedge clk);
         n++;
      end while (dack_n && n < 20);
      check("R1 ack latency", 32'(n), 32'd3);
      dreq_n = 1'b1;
      do begin
         @(negedge clk);
         m++;
         if (m == 1) check("R2 ack one cycle", 32'(dack_n), 32'd1);
      end while (!m_valid && m < 20);
      check("R3 bus start latency", 32'(m), 32'd4);
      check("R5 read first", 32'(m_we), 32'd0);
      check("R5 read address", 32'(m_addr), 32'h001000);
      a0 = m_addr;
      @(negedge clk);
      check("R6 address held", 32'(m_addr), 32'(a0));
      tick(10);
      check("R5 read addr", 32'(last_rd_addr), 32'h001000);
      check("R5 write addr", 32'(last_wr_addr), 32'h002000);
      check("R5 write data", last_wr_data, 32'h5A001000);
      check("R7 single write", 32'(wr_cnt), 32'd1);
      check("R2 single ack", 32'(dack_cnt), 32'd1);
      check("R7 bus released", 32'(bus_req), 32'd0);
   endtask

   task automatic t_short_hold();
      pulse_req(4);
      tick(25);
      check("R7 four-clock hold one transfer", 32'(wr_cnt), 32'd2);
      check("R8 source advanced", 32'(last_rd_addr), 32'h001004);
      check("R8 destination fixed", 32'(last_wr_addr), 32'h002000);
   endtask

   task automatic t_long_hold();
      pulse_req(40);
      tick(20);
      check("R7 long hold one transfer", 32'(wr_cnt), 32'd3);
      check("R7 long hold one ack", 32'(dack_cnt), 32'd3);
   endtask

   task automatic t_disabled();
      int b0 = breq_cyc;
      chan_en = 1'b0;
      pulse_req(6);
      tick(20);
      check("R4 no ack when disabled", 32'(dack_cnt), 32'd3);
      check("R4 no bus request", 32'(breq_cyc), 32'(b0));
      check("R4 no transfer", 32'(wr_cnt), 32'd3);
      chan_en = 1'b1;
   endtask

   task automatic t_grant_wait();
      gnt_en = 1'b0;
      pulse_req(4);
      tick(15);
      check("R6 request pending", 32'(bus_req), 32'd1);
      check("R6 no cycle without grant", 32'(m_valid), 32'd0);
      gnt_en = 1'b1;
      tick(10);
      check("R6 completes after grant", 32'(wr_cnt), 32'd4);
      check("R9 done at zero", 32'(done), 32'd1);
   endtask

   task automatic t_done_rearm();
      pulse_req(4);
      tick(20);
      check("R9 ignored when done", 32'(dack_cnt), 32'd4);
      load(24'h003000, 24'h004000, 16'd4, 1'b1, 1'b1);
      check("R9 reload clears done", 32'(done), 32'd0);
      pulse_req(4);
      tick(20);
      check("R9 transfer after reload", 32'(wr_cnt), 32'd5);
      check("R9 done again", 32'(done), 32'd1);
      load(24'h005000, 24'h006000, 16'd8, 1'b0, 1'b1);
      pulse_req(3);
      tick(20);
      pulse_req(3);
      tick(20);
      check("R8 destination advanced", 32'(last_wr_addr), 32'h006004);
      check("R8 source fixed", 32'(last_rd_addr), 32'h005000);
      check("R9 done after two units", 32'(done), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_basic();
      t_short_hold();
      t_long_hold();
      t_disabled();
      t_grant_wait();
      t_done_rearm();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule